// File: doc/BRIEF.md
# Multi-Mode Fixed-Point Rounding Unit

This unit narrows a signed two's-complement fixed-point word. It removes a fixed number of fractional bits from the least significant end and fits the result into a narrower output word. A 3-bit select, which can change from one sample to the next, picks one of seven rounding rules. The rules differ in direction and in how they break ties. A separate enable picks what happens when the rounded value does not fit the output word: it either clamps to the output range or wraps modulo the output width.

The unit sits between a wide arithmetic stage, such as an accumulator or a divider, and a narrower data path. Each sample is presented together with a valid strobe. The result appears one clock later with its own valid and an overflow flag. One rule, "simplest", does not fix a direction of its own. It takes its direction from a configuration input that states how the surrounding system rounds signed integer division.

Top module: `fxp_round_unit`

## Requirements
- R1: Mode code 0 (floor) rounds toward negative infinity. Code 7 behaves exactly like code 0.
- R2: Mode code 1 (ceiling) rounds toward positive infinity for both signs.
- R3: Mode code 2 (zero) rounds toward zero. A negative input with nonzero dropped bits rounds up, and a positive one rounds down.
- R4: Mode code 3 (nearest) rounds to the nearest representable value. An exact half goes toward positive infinity.
- R5: Mode code 4 (round) rounds to the nearest value. An exact half goes away from zero.
- R6: Mode code 5 (convergent) rounds to the nearest value. An exact half goes to the result whose least significant bit is 0.
- R7: Mode code 6 (simplest) acts as floor when `div_rounds_floor` is 1, and as toward-zero when it is 0.
- R8: `ovf_out` is 1 exactly when the rounded value lies outside the signed range of OUT_W bits. This holds with saturation on or off.
- R9: With `sat_en` = 1, an out-of-range result becomes the largest positive or the most negative OUT_W-bit value, whichever matches the sign of the rounded value.
- R10: With `sat_en` = 0, an out-of-range result is the low OUT_W bits of the rounded value.
- R11: `valid_out` equals `valid_in` delayed by one clock. The result registers load only when `valid_in` is 1, and otherwise hold their value.
- R12: During reset, `valid_out`, `data_out` and `ovf_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| valid_in | input | 1 | Sample strobe |
| data_in | input | IN_W | Signed input with DROP_W fractional bits to remove |
| mode_sel | input | 3 | Rounding rule code (see R1 to R7) |
| sat_en | input | 1 | 1 saturates on overflow, 0 wraps |
| div_rounds_floor | input | 1 | Resolves the simplest rule: 1 gives floor, 0 gives toward zero |
| valid_out | output | 1 | Result strobe, one cycle after `valid_in` |
| data_out | output | OUT_W | Signed rounded and fitted result |
| ovf_out | output | 1 | Rounded value did not fit OUT_W bits |

## Verification
The bench builds the unit with IN_W = 16, DROP_W = 4 and OUT_W = 10. The rounded value then spans 13 bits, while the output holds only -512 to 511. Random 16-bit inputs therefore overflow in roughly three cases out of four. Directed small inputs, with the four dropped bits set to exactly binary 1000, reach every tie-breaking rule for both signs, and also odd and even integer parts for the convergent rule.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
  typedef enum logic [2:0] {
    RM_FLOOR   = 3'd0,
    RM_CEIL    = 3'd1,
    RM_ZERO    = 3'd2,
    RM_NEAREST = 3'd3,
    RM_ROUND   = 3'd4,
    RM_CONV    = 3'd5,
    RM_SIMPLE  = 3'd6,
    RM_SPARE   = 3'd7
  } rnd_mode_e;
endpackage

// File: rtl/fxr_round_core.sv
module fxr_round_core import fxr_pkg::*; #(
  parameter int IN_W   = 16,
  parameter int DROP_W = 4,
  localparam int RW    = IN_W - DROP_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IN_W-1:0]      din,
  input  logic [2:0]           mode,
  input  logic                 simple_floor,
  output logic signed [RW-1:0] rnd
);
  localparam logic [DROP_W-1:0] LOW_MASK = {DROP_W{1'b1}} >> 1;

  logic signed [RW-1:0] base;
  logic [DROP_W-1:0]    frac;
  logic                 neg, any_frac, tie, above;
  logic                 bump;
  rnd_mode_e            eff;

  always_comb begin
    base     = $signed({din[IN_W-1], din[IN_W-1:DROP_W]});
    frac     = din[DROP_W-1:0];
    neg      = din[IN_W-1];
    any_frac = |frac;
    tie      = frac[DROP_W-1] & ~|(frac & LOW_MASK);
    above    = frac[DROP_W-1] & |(frac & LOW_MASK);
    case (mode)
      RM_SIMPLE: eff = simple_floor ? RM_FLOOR : RM_ZERO;
      RM_SPARE:  eff = RM_FLOOR;
      default:   eff = rnd_mode_e'(mode);
    endcase
    case (eff)
      RM_CEIL:    bump = any_frac;
      RM_ZERO:    bump = neg & any_frac;
      RM_NEAREST: bump = frac[DROP_W-1];
      RM_ROUND:   bump = above | (tie & ~neg);
      RM_CONV:    bump = above | (tie & base[0]);
      default:    bump = 1'b0;
    endcase
    rnd = base + $signed({{(RW-1){1'b0}}, bump});
  end

  // Every rule lands on the floor value or one step above it (R1, R2)
  assert_step_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd == base) || (rnd == base + 1'b1));

  // Toward-zero on a positive input never moves up (R3)
  assert_zero_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eff == RM_ZERO && !neg) |-> (rnd == base));
endmodule

// File: rtl/fxr_fit.sv
module fxr_fit #(
  parameter int RW    = 13,
  parameter int OUT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [RW-1:0]    rnd,
  input  logic                    sat_en,
  output logic signed [OUT_W-1:0] fit,
  output logic                    ovf
);
  localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  generate
    if (OUT_W < RW) begin : g_narrow
      logic [RW-OUT_W:0] hi;
      always_comb begin
        hi  = rnd[RW-1:OUT_W-1];
        ovf = ~((&hi) | ~(|hi));
        if (ovf && sat_en) fit = rnd[RW-1] ? OUT_MIN : OUT_MAX;
        else               fit = rnd[OUT_W-1:0];
      end

      // Wrapping keeps the low bits of the rounded value (R10)
      assert_wrap_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sat_en |-> (fit == rnd[OUT_W-1:0]));
    end else begin : g_wide
      always_comb begin
        ovf = 1'b0;
        fit = OUT_W'(rnd);
      end
    end
  endgenerate

  // A clamped result sits on a range end (R9)
  assert_sat_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_en && ovf) |-> (fit == OUT_MAX || fit == OUT_MIN));

  // Without overflow the value passes unchanged (R8)
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |-> (fit == rnd));
endmodule

// File: rtl/fxp_round_unit.sv
module fxp_round_unit #(
  parameter int IN_W   = 16,
  parameter int DROP_W = 4,
  parameter int OUT_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [IN_W-1:0]  data_in,
  input  logic [2:0]       mode_sel,
  input  logic             sat_en,
  input  logic             div_rounds_floor,
  output logic             valid_out,
  output logic [OUT_W-1:0] data_out,
  output logic             ovf_out
);
  localparam int RW = IN_W - DROP_W + 1;

  logic signed [RW-1:0]    rnd;
  logic signed [OUT_W-1:0] fit;
  logic                    ovf;
  logic                    vld_d, vld_q;
  logic [OUT_W-1:0]        dat_d, dat_q;
  logic                    ovf_d, ovf_q;

  fxr_round_core #(.IN_W(IN_W), .DROP_W(DROP_W)) u_core (
    .clk(clk), .rst_n(rst_n), .din(data_in), .mode(mode_sel),
    .simple_floor(div_rounds_floor), .rnd(rnd)
  );

  fxr_fit #(.RW(RW), .OUT_W(OUT_W)) u_fit (
    .clk(clk), .rst_n(rst_n), .rnd(rnd), .sat_en(sat_en),
    .fit(fit), .ovf(ovf)
  );

  always_comb begin
    vld_d = valid_in;
    dat_d = dat_q;
    ovf_d = ovf_q;
    if (valid_in) begin
      dat_d = fit;
      ovf_d = ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      ovf_q <= ovf_d;
    end
  end

  assign valid_out = vld_q;
  assign data_out  = dat_q;
  assign ovf_out   = ovf_q;

  assert_valid_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (!valid_out && $stable(data_out) && $stable(ovf_out)));
  assert_reset_state_R12: assert property (@(posedge clk)
    !rst_n |-> (!valid_out && data_out == '0 && !ovf_out));
endmodule

// File: tb/fxp_round_unit_tb_top.sv
module fxp_round_unit_tb_top;
  localparam int IN_W = 16, DROP_W = 4, OUT_W = 10;
  localparam int ONE = 1 << DROP_W, HALF = ONE / 2;
  localparam int OMAX = (1 << (OUT_W - 1)) - 1, OMIN = -(1 << (OUT_W - 1));

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_in = 1'b0;
  logic [IN_W-1:0] data_in = '0;
  logic [2:0] mode_sel = '0;
  logic sat_en = 1'b0, div_rounds_floor = 1'b0;
  logic valid_out, ovf_out;
  logic [OUT_W-1:0] data_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fxp_round_unit #(.IN_W(IN_W), .DROP_W(DROP_W), .OUT_W(OUT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .data_in(data_in),
    .mode_sel(mode_sel), .sat_en(sat_en), .div_rounds_floor(div_rounds_floor),
    .valid_out(valid_out), .data_out(data_out), .ovf_out(ovf_out)
  );

  function automatic int rounded(input int v, input int mode, input bit cfg);
    int fl, fr, m;
    fl = v >>> DROP_W;
    fr = v - fl * ONE;
    m  = mode;
    if (m == 6) m = cfg ? 0 : 2;
    if (m == 7) m = 0;
    case (m)
      1: return fl + ((fr != 0) ? 1 : 0);
      2: return (v < 0 && fr != 0) ? fl + 1 : fl;
      3: return fl + ((fr >= HALF) ? 1 : 0);
      4: return (fr > HALF || (fr == HALF && v >= 0)) ? fl + 1 : fl;
      5: return (fr > HALF || (fr == HALF && (fl & 1) != 0)) ? fl + 1 : fl;
      default: return fl;
    endcase
  endfunction

  function automatic string tag_of(input int mode, input bit cfg);
    case (mode)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return cfg ? "R7 floor" : "R7 zero";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int v, input int mode, input bit sat, input bit cfg);
    int r, e, act;
    bit eo;
    string tg;
    r  = rounded(v, mode, cfg);
    eo = (r > OMAX || r < OMIN);
    if (eo && sat) e = (r > 0) ? OMAX : OMIN;
    else begin
      e = r & ((1 << OUT_W) - 1);
      if (e > OMAX) e -= (1 << OUT_W);
    end
    tg = tag_of(mode, cfg);
    if (eo) tg = sat ? {tg, "/R9"} : {tg, "/R10"};
    @(negedge clk);
    valid_in = 1'b1; data_in = IN_W'(v); mode_sel = 3'(mode);
    sat_en = sat; div_rounds_floor = cfg;
    @(negedge clk);
    valid_in = 1'b0;
    act = int'($signed(data_out));
    check(act == e, tg, act, e);
    check(ovf_out == eo, "R8", int'(ovf_out), int'(eo));
    check(valid_out == 1'b1, "R11", int'(valid_out), 1);
  endtask

  initial begin
    int seed;
    int hold;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(valid_out == 1'b0 && data_out == '0 && ovf_out == 1'b0, "R12",
          int'(data_out), 0);
    rst_n = 1'b1;
    // Directed ties and near-ties for every rule, both signs
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < 2; c++) begin
        apply( 2*ONE + HALF, m, 1'b0, c[0]);  // +2.5
        apply( 3*ONE + HALF, m, 1'b0, c[0]);  // +3.5
        apply(-2*ONE - HALF, m, 1'b0, c[0]);  // -2.5
        apply(-3*ONE - HALF, m, 1'b0, c[0]);  // -3.5
        apply( 5*ONE + 3,    m, 1'b0, c[0]);
        apply(-5*ONE - 3,    m, 1'b0, c[0]);
        apply(-ONE + 1,      m, 1'b0, c[0]);
        apply( 7*ONE,        m, 1'b0, c[0]);
      end
    end
    // Range edges: rounding up past the maximum, far below the minimum
    apply(OMAX*ONE + HALF, 1, 1'b1, 1'b0);
    apply(OMAX*ONE + HALF, 1, 1'b0, 1'b0);
    apply(OMAX*ONE,        1, 1'b1, 1'b0);
    apply(OMIN*ONE - 1,    0, 1'b1, 1'b0);
    apply(OMIN*ONE - 1,    2, 1'b1, 1'b0);
    apply(-32768,          0, 1'b0, 1'b0);
    apply(32767,           4, 1'b1, 1'b0);
    // Hold: idle cycles must not change the result (R11)
    hold = int'($signed(data_out));
    @(negedge clk);
    data_in = 16'h1234; mode_sel = 3'd1; sat_en = 1'b1;
    @(negedge clk);
    check(valid_out == 1'b0, "R11", int'(valid_out), 0);
    check(int'($signed(data_out)) == hold, "R11", int'($signed(data_out)), hold);
    // Random mix
    for (int i = 0; i < 2000; i++) begin
      int v;
      v = $urandom_range(0, 65535);
      if (v >= 32768) v -= 65536;
      if (i % 2 == 0) v = v >>> 2;
      apply(v, $urandom_range(0, 7), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "watchdog", cyc, 0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule